// File: doc/BRIEF.md
# Ternary Lookup Table with Priority Resolution

This block is a small associative table of 64-bit entries, each with a validity bit. A caller searches it in one of two ways. A ternary search takes a 32-bit key and returns the first stored prefix-style pattern that covers that key. A masked binary search compares the whole 64-bit word against a comparand and ignores the bit positions chosen by one of seven programmable mask registers. Both searches report the lowest matching index, a match flag and a multiple-match flag. The table also reports a full flag and the lowest empty index at all times.

Each ternary digit is kept as two word bits 32 apart. A ternary search builds both the comparand and the mask from the key and its complement. Because of this, one array serves longest-prefix lookups, with longer prefixes placed at lower indices, and exact lookups. Entries are written one 32-bit half at a time by index, or whole at the lowest free slot. An entry is removed by index or by associative match, and the affected index is always reported on the result address.

Top module: `tcam_top`

## Requirements
- R1: Ternary digit n is held in word bits n and n+32. A 0 is stored as (bit n=0, bit n+32=1), a 1 as (1,0), and don't-care as (0,0). In a ternary search (op code 4), a key bit of 0 matches a stored 0 or don't-care, and a key bit of 1 matches a stored 1 or don't-care.
- R2: When several entries match, `resultAddr` reports the lowest matching index.
- R3: A search with no matching entry clears `matchFlag` and sets `resultAddr` to all ones.
- R4: `multiMatch` is 1 after a search exactly when two or more entries matched.
- R5: Only entries whose validity bit is 1 take part in a search.
- R6: A binary search (op code 5) compares all 64 bits against `wordIn`. The mask is register `maskSel`, or no mask when `maskSel` is 0. A mask bit of 1 excludes that bit position from the comparison. Op code 6 loads `wordIn` into mask register `maskSel` for values 1 to 7 and does nothing when `maskSel` is 0.
- R7: A random write (op code 2) stores `wordIn[31:0]` into bits 31:0 of entry `opIdx` when `segHi` is 0, or into bits 63:32 when `segHi` is 1. It sets the entry's validity bit to `vldIn` and reports `opIdx` on `resultAddr`.
- R8: A read (op code 1) returns the selected half of entry `opIdx` on `rdData` and reports `opIdx` on `resultAddr`.
- R9: A free-slot write (op code 3) stores `wordIn` at the lowest empty index, marks it valid and reports that index. When the table is full, nothing is stored and `resultAddr` becomes all ones.
- R10: `fullFlag` is 1 only when every entry is valid. `nextFree` gives the lowest empty index, or all ones when the table is full.
- R11: A delete by index (op code 7) clears the validity bit of `opIdx` and reports `opIdx` on `resultAddr`.
- R12: A delete by match (op code 8) uses the same compare as R6. It clears the validity bit of the lowest matching entry and reports that index, or all ones when nothing matches.
- R13: Every operation takes effect at the clock edge where `opValid` is sampled, and its results appear right after that edge. `matchFlag` and `multiMatch` change only on searches (op codes 4 and 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Operation code (see requirements) |
| opIdx | input | IDXW | Entry index for read, write and delete by index |
| segHi | input | 1 | Half select: 0 = bits 31:0, 1 = bits 63:32 |
| vldIn | input | 1 | Validity value for random writes |
| maskSel | input | 3 | Mask register select, 0 = no mask |
| wordIn | input | 64 | Data, key (bits 31:0) or comparand |
| rdData | output | 32 | Read data half |
| resultAddr | output | IDXW | Match, accessed or deleted index |
| matchFlag | output | 1 | Last search found a match |
| multiMatch | output | 1 | Last search found two or more matches |
| fullFlag | output | 1 | All entries valid |
| nextFree | output | IDXW | Lowest empty index, all ones when full |

## Verification
The ternary search is tried with keys that several nested prefixes cover, that only shorter prefixes cover, and that only the zero-length default covers. This separates lowest-index selection from wrong don't-care decoding. Binary searches are run with no mask, with a mask that hides the low half, and with a comparand that nothing matches. These show whether mask polarity and register selection are correct. Deletions are followed by repeated searches, and the table is filled past capacity with free-slot writes, to expose validity handling. A long run of random mixed operations is compared every cycle against a behavioural model.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_READ     = 4'd1,
    OP_WRITE    = 4'd2,
    OP_WRFREE   = 4'd3,
    OP_TSEARCH  = 4'd4,
    OP_BSEARCH  = 4'd5,
    OP_LDMASK   = 4'd6,
    OP_DELIDX   = 4'd7,
    OP_DELMATCH = 4'd8
  } tcamOp_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic wrFree;
    logic tSearch;
    logic bSearch;
    logic ldMask;
    logic delIdx;
    logic delMatch;
  } tcamStrobe_t;
endpackage

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  vec,
  output logic          anyHit,
  output logic [IW-1:0] hitIdx
);
  always_comb begin
    anyHit = |vec;
    hitIdx = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) hitIdx = IW'(i);
    end
  end
endmodule

// File: rtl/tcam_ctrl.sv
module tcam_ctrl
  import tcam_pkg::*;
(
  input  logic        opValid,
  input  logic [3:0]  opCode,
  output tcamStrobe_t strb
);
  always_comb begin
    strb = '0;
    if (opValid) begin
      case (tcamOp_e'(opCode))
        OP_READ:     strb.rd       = 1'b1;
        OP_WRITE:    strb.wr       = 1'b1;
        OP_WRFREE:   strb.wrFree   = 1'b1;
        OP_TSEARCH:  strb.tSearch  = 1'b1;
        OP_BSEARCH:  strb.bSearch  = 1'b1;
        OP_LDMASK:   strb.ldMask   = 1'b1;
        OP_DELIDX:   strb.delIdx   = 1'b1;
        OP_DELMATCH: strb.delMatch = 1'b1;
        default:     strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/tcam_dp.sv
module tcam_dp
  import tcam_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int HALFW = 32,
  parameter int NMASK = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tcamStrobe_t              strb,
  input  logic [$clog2(DEPTH)-1:0] opIdx,
  input  logic                     segHi,
  input  logic                     vldIn,
  input  logic [$clog2(NMASK)-1:0] maskSel,
  input  logic [2*HALFW-1:0]       wordIn,
  output logic [HALFW-1:0]         rdData,
  output logic [$clog2(DEPTH)-1:0] resultAddr,
  output logic                     matchFlag,
  output logic                     multiMatch,
  output logic                     fullFlag,
  output logic [$clog2(DEPTH)-1:0] nextFree
);
  localparam int IDXW  = $clog2(DEPTH);
  localparam int WORDW = 2 * HALFW;

  logic [WORDW-1:0] memQ  [DEPTH];
  logic [DEPTH-1:0] validQ;
  logic [WORDW-1:0] maskQ [NMASK];
  logic [WORDW-1:0] cmpWord, cmpMask;
  logic [DEPTH-1:0] hitVec;
  logic             hitAny, freeAny, hitMulti;
  logic [IDXW-1:0]  hitIdx, freeIdx;

  // ternary key expands to comparand and mask alike; binary uses chosen mask
  always_comb begin
    if (strb.tSearch) begin
      cmpWord = {~wordIn[HALFW-1:0], wordIn[HALFW-1:0]};
      cmpMask = cmpWord;
    end else begin
      cmpWord = wordIn;
      cmpMask = maskQ[maskSel];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gCmp
    assign hitVec[g] = validQ[g] & ~|((memQ[g] ^ cmpWord) & ~cmpMask);
  end

  assign hitMulti = |(hitVec & (hitVec - DEPTH'(1)));

  tcam_prio #(.N(DEPTH), .IW(IDXW)) uHitPrio (
    .vec(hitVec), .anyHit(hitAny), .hitIdx(hitIdx)
  );
  tcam_prio #(.N(DEPTH), .IW(IDXW)) uFreePrio (
    .vec(~validQ), .anyHit(freeAny), .hitIdx(freeIdx)
  );

  assign fullFlag = ~freeAny;
  assign nextFree = freeIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memQ[i] <= '0;
      for (int m = 0; m < NMASK; m++) maskQ[m] <= '0;
      validQ     <= '0;
      rdData     <= '0;
      resultAddr <= '1;
      matchFlag  <= 1'b0;
      multiMatch <= 1'b0;
    end else begin
      if (strb.rd) begin
        rdData     <= segHi ? memQ[opIdx][WORDW-1:HALFW] : memQ[opIdx][HALFW-1:0];
        resultAddr <= opIdx;
      end
      if (strb.wr) begin
        if (segHi) memQ[opIdx][WORDW-1:HALFW] <= wordIn[HALFW-1:0];
        else       memQ[opIdx][HALFW-1:0]     <= wordIn[HALFW-1:0];
        validQ[opIdx] <= vldIn;
        resultAddr    <= opIdx;
      end
      if (strb.wrFree) begin
        if (freeAny) begin
          memQ[freeIdx]   <= wordIn;
          validQ[freeIdx] <= 1'b1;
        end
        resultAddr <= freeIdx;
      end
      if (strb.tSearch || strb.bSearch) begin
        matchFlag  <= hitAny;
        multiMatch <= hitMulti;
        resultAddr <= hitIdx;
      end
      if (strb.ldMask && maskSel != '0) maskQ[maskSel] <= wordIn;
      if (strb.delIdx) begin
        validQ[opIdx] <= 1'b0;
        resultAddr    <= opIdx;
      end
      if (strb.delMatch) begin
        if (hitAny) validQ[hitIdx] <= 1'b0;
        resultAddr <= hitIdx;
      end
    end
  end

  assert_multi_needs_match_R4: assert property (@(posedge clk) disable iff (!rstN)
    multiMatch |-> matchFlag);
  assert_miss_all_ones_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.tSearch || strb.bSearch) && !hitAny) |=> (!matchFlag && resultAddr == '1));
  assert_full_suppress_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrFree && fullFlag) |=> (resultAddr == '1 && fullFlag));
  assert_delidx_report_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.delIdx |=> (!fullFlag && resultAddr == $past(opIdx)));
  assert_flags_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.tSearch || strb.bSearch) |=> ($stable(matchFlag) && $stable(multiMatch)));
  assert_hit_is_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    hitAny |-> validQ[hitIdx]);
endmodule

// File: rtl/tcam_top.sv
module tcam_top
  import tcam_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [3:0]      opCode,
  input  logic [IDXW-1:0] opIdx,
  input  logic            segHi,
  input  logic            vldIn,
  input  logic [2:0]      maskSel,
  input  logic [63:0]     wordIn,
  output logic [31:0]     rdData,
  output logic [IDXW-1:0] resultAddr,
  output logic            matchFlag,
  output logic            multiMatch,
  output logic            fullFlag,
  output logic [IDXW-1:0] nextFree
);
  tcamStrobe_t strb;

  tcam_ctrl uCtrl (.opValid(opValid), .opCode(opCode), .strb(strb));

  tcam_dp #(.DEPTH(DEPTH), .HALFW(32), .NMASK(8)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .opIdx(opIdx), .segHi(segHi),
    .vldIn(vldIn), .maskSel(maskSel), .wordIn(wordIn), .rdData(rdData),
    .resultAddr(resultAddr), .matchFlag(matchFlag), .multiMatch(multiMatch),
    .fullFlag(fullFlag), .nextFree(nextFree)
  );
endmodule

// File: tb/sim_tcam_top.sv
`timescale 1ns/1ps
module sim_tcam_top;
  localparam int DEPTH = 16;
  localparam int IDXW  = 4;
  localparam logic [IDXW-1:0] ONES = '1;

  logic clk = 0, rstN = 0, opValid = 0, segHi = 0, vldIn = 0;
  logic [3:0] opCode = 0;
  logic [IDXW-1:0] opIdx = 0;
  logic [2:0] maskSel = 0;
  logic [63:0] wordIn = 0;
  logic [31:0] rdData;
  logic [IDXW-1:0] resultAddr, nextFree;
  logic matchFlag, multiMatch, fullFlag;

  always #2 clk = ~clk;

  tcam_top #(.DEPTH(DEPTH)) u0 (.*);

  int checks = 0, failures = 0;
  logic [63:0] mMem [DEPTH];
  bit   [DEPTH-1:0] mVal;
  logic [63:0] mMask [8];
  logic [IDXW-1:0] eRes = ONES;
  logic [31:0] eRd = 0;
  bit eMatch = 0, eMulti = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit mHit(int i, bit tern, logic [63:0] w, logic [63:0] msk);
    if (!mVal[i]) return 0;
    if (tern) begin
      for (int n = 0; n < 32; n++) begin
        logic lo = mMem[i][n], hi = mMem[i][n+32];
        if (lo && hi) return 0;
        if (lo && !w[n]) return 0;
        if (hi && w[n]) return 0;
      end
      return 1;
    end
    for (int b = 0; b < 64; b++)
      if (!msk[b] && mMem[i][b] !== w[b]) return 0;
    return 1;
  endfunction

  function automatic int firstFree();
    for (int i = 0; i < DEPTH; i++) if (!mVal[i]) return i;
    return -1;
  endfunction

  function automatic logic [63:0] tEnc(logic [31:0] v, int len);
    logic [31:0] m = (len == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - len));
    return {~v & m, v & m};
  endfunction

  task automatic modelStep(int op, int idx, bit seg, bit vld, int ms, logic [63:0] w);
    int cnt = 0, first = -1, ff;
    case (op)
      1: begin eRd = seg ? mMem[idx][63:32] : mMem[idx][31:0]; eRes = idx; end
      2: begin
        if (seg) mMem[idx][63:32] = w[31:0]; else mMem[idx][31:0] = w[31:0];
        mVal[idx] = vld; eRes = idx;
      end
      3: begin
        ff = firstFree();
        if (ff >= 0) begin mMem[ff] = w; mVal[ff] = 1; eRes = ff; end
        else eRes = ONES;
      end
      4, 5, 8: begin
        for (int i = 0; i < DEPTH; i++)
          if (mHit(i, op == 4, w, mMask[ms])) begin cnt++; if (first < 0) first = i; end
        eRes = (first < 0) ? ONES : first;
        if (op == 8) begin if (first >= 0) mVal[first] = 0; end
        else begin eMatch = cnt > 0; eMulti = cnt > 1; end
      end
      6: if (ms != 0) mMask[ms] = w;
      7: begin mVal[idx] = 0; eRes = idx; end
      default: ;
    endcase
  endtask

  task automatic compareAll(string tag);
    int ff = firstFree();
    chk(tag, "resultAddr", resultAddr, eRes);
    chk(tag, "matchFlag", matchFlag, eMatch);
    chk(tag, "multiMatch", multiMatch, eMulti);
    chk(tag, "fullFlag", fullFlag, ff < 0);
    chk(tag, "nextFree", nextFree, (ff < 0) ? ONES : ff);
    chk(tag, "rdData", rdData, eRd);
  endtask

  task automatic doOp(string tag, int op, int idx, bit seg, bit vld, int ms, logic [63:0] w);
    opValid = 1; opCode = op; opIdx = idx; segHi = seg; vldIn = vld; maskSel = ms; wordIn = w;
    @(posedge clk);
    modelStep(op, idx, seg, vld, ms, w);
    @(negedge clk);
    opValid = 0;
    compareAll(tag);
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R13 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mMem[i] = 0;
    for (int m = 0; m < 8; m++) mMask[m] = 0;
    mVal = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    compareAll("R10");
    // mask registers
    doOp("R6", 6, 0, 0, 0, 1, 64'h0000_0000_FFFF_FFFF);
    doOp("R6", 6, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    // prefixes at lowest free slots: /24, /16, /8, default
    doOp("R9", 3, 0, 0, 0, 0, tEnc(32'h0A01_0200, 24));
    doOp("R9", 3, 0, 0, 0, 0, tEnc(32'h0A01_0000, 16));
    doOp("R9", 3, 0, 0, 0, 0, tEnc(32'h0A00_0000, 8));
    doOp("R9", 3, 0, 0, 0, 0, tEnc(32'h0, 0));
    doOp("R2", 4, 0, 0, 0, 0, {32'h0, 32'h0A01_0207});
    doOp("R1", 4, 0, 0, 0, 0, {32'h0, 32'h0A01_0307});
    doOp("R4", 4, 0, 0, 0, 0, {32'h0, 32'hC0A8_0001});
    // random half writes, exact entry at idx 5
    doOp("R7", 2, 5, 0, 0, 0, 64'h1234_5678);
    doOp("R7", 2, 5, 1, 1, 0, 64'h9ABC_DEF0);
    doOp("R6", 5, 0, 0, 0, 0, 64'h9ABC_DEF0_1234_5678);
    doOp("R6", 5, 0, 0, 0, 1, 64'h9ABC_DEF0_FFFF_0000);
    doOp("R3", 5, 0, 0, 0, 0, 64'h9ABC_DEF0_FFFF_0000);
    doOp("R8", 1, 5, 1, 0, 0, 64'h0);
    doOp("R13", 1, 5, 0, 0, 0, 64'h0);
    // delete and re-search
    doOp("R11", 7, 0, 0, 0, 0, 64'h0);
    doOp("R5", 4, 0, 0, 0, 0, {32'h0, 32'h0A01_0207});
    doOp("R12", 8, 0, 0, 0, 1, 64'h9ABC_DEF0_0000_0000);
    doOp("R12", 8, 0, 0, 0, 1, 64'h9ABC_DEF0_0000_0000);
    doOp("R5", 5, 0, 0, 0, 0, 64'h9ABC_DEF0_1234_5678);
    // fill until full, then overflow
    for (int k = 0; k < DEPTH + 2; k++)
      doOp("R9", 3, 0, 0, 0, 0, {32'hA5A5_0000 + k, 32'h5A5A_0000 + k});
    compareAll("R10");
    doOp("R11", 7, 9, 0, 0, 0, 64'h0);
    doOp("R10", 3, 0, 0, 0, 0, 64'h77);
    // random mixed traffic
    for (int k = 0; k < 3000; k++) begin
      int op = $urandom_range(1, 8);
      logic [63:0] w = {$urandom, $urandom};
      if (op == 4 && k % 3 == 0) w[31:0] = mMem[$urandom_range(0, DEPTH-1)][31:0];
      if (op == 5 && k % 2 == 0) w = mMem[$urandom_range(0, DEPTH-1)];
      if (op == 3 && k % 2 == 0) w = tEnc($urandom, $urandom_range(0, 32));
      doOp("R13", op, $urandom_range(0, DEPTH-1), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 7), w);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule